// File: doc/BRIEF.md
# Paged SRAM Address Mapper

This block widens the data addresses of an 8-bit processor. The processor can only name 256 bytes. The mapper adds a 3-bit page number on top of each 8-bit offset. The result is an 11-bit physical address that spans eight SRAM pages of 256 bytes each. The page is picked separately for each kind of access:

- Plain accesses use a current-page pointer.
- Indexed accesses use an indexed-page pointer.
- Stack traffic uses a stack-page pointer.
- Move-indirect reads use their own read-page pointer.
- Move-indirect writes use their own write-page pointer.

A single page-mode enable gates the plain and indexed paths. While the enable is clear, those two paths fall back to page 0. Stack and move-indirect traffic always use their own pointers, whatever the mode.

The processor updates the pointers and the mode bit through simple write strobes. Interrupt entry saves the mode bit and clears it, so a service routine always starts in page 0. The matching return restores the saved bit. The address path itself is combinational: the physical address follows the access inputs in the same cycle, using the register contents latched at the last clock edge.

Top module: `paged_sram_mapper`

## Requirements
- R1: After synchronous reset (rst high at a clock edge), all five page pointers and the mode bit are 0, so every access class maps logical address A to physical address {3'd0, A}.
- R2: Physical address bits [7:0] always equal the logical address, and bits [10:8] carry the selected page, for every access class.
- R3: A plain access (class code 0) uses the current-page pointer when the mode bit is 1, and page 0 when the mode bit is 0.
- R4: An indexed access (class code 1) uses the indexed-page pointer when the mode bit is 1, and page 0 when the mode bit is 0.
- R5: A stack access (class code 2) always uses the stack-page pointer, whatever the mode bit.
- R6: A move-indirect read (class code 3) uses the read-page pointer, and a move-indirect write (class code 4) uses the write-page pointer, both whatever the mode bit.
- R7: When ptr_we is high at a clock edge, the pointer named by ptr_sel is loaded with ptr_wdata (selector codes: 0 current, 1 indexed, 2 stack, 3 move-read, 4 move-write). The new value shows from the following cycle; before that edge the old value is still used. Selector codes 5 to 7 change no pointer.
- R8: When mode_we is high at a clock edge, the mode bit is loaded with mode_wdata.
- R9: When irq_enter is high at a clock edge, the mode bit is saved and then cleared; this takes priority over a mode_we in the same cycle. When irq_return is high at an edge (and irq_enter is low), the mode bit takes back the saved value.
- R10: Class codes 5 to 7 are treated as plain accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 8 | Logical data address from the processor |
| acc_class | input | 3 | Access class code: 0 plain, 1 indexed, 2 stack, 3 move-read, 4 move-write |
| ptr_we | input | 1 | Page-pointer write strobe |
| ptr_sel | input | 3 | Which pointer to write |
| ptr_wdata | input | 3 | New pointer value |
| mode_we | input | 1 | Mode bit write strobe |
| mode_wdata | input | 1 | New mode bit value |
| irq_enter | input | 1 | Interrupt entry: save the mode bit and clear it |
| irq_return | input | 1 | Return from interrupt: restore the saved mode bit |
| phys_addr | output | 11 | Physical SRAM address {page, offset} |

## Verification
The bench loads a distinct value into every pointer, so that a design that routes a class to the wrong pointer shows a wrong page. It then toggles the mode bit between accesses. This catches a design that gates stack or move-indirect traffic by mode, which would send them to page 0, and a design that fails to gate the plain or indexed path, which would leak the pointer while the mode is off.

The interrupt tests check three cases:
- Entry clears the mode bit even when mode_we is asserted in the same cycle.
- Return restores the bit as it was before entry, not a fixed 1.
- Stack traffic keeps its own page throughout.

The bench also writes with an unused selector and checks that no pointer is corrupted. It samples during a write cycle to confirm that the old page still applies until the clock edge.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    localparam int OFF_W   = 8;
    localparam int PG_W    = 3;
    localparam int PHYS_W  = OFF_W + PG_W;
    localparam int NUM_PTR = 5;
    localparam int CLS_W   = 3;
    localparam int SEL_W   = 3;

    typedef enum logic [CLS_W-1:0] {
        ACC_PLAIN = 3'd0,
        ACC_INDEX = 3'd1,
        ACC_STACK = 3'd2,
        ACC_MVRD  = 3'd3,
        ACC_MVWR  = 3'd4
    } acc_class_e;

    typedef enum logic [SEL_W-1:0] {
        PTR_CUR = 3'd0,
        PTR_IDX = 3'd1,
        PTR_STK = 3'd2,
        PTR_MVR = 3'd3,
        PTR_MVW = 3'd4
    } ptr_sel_e;

    typedef logic [PG_W-1:0]  page_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef struct packed {
        page_t cur;
        page_t idx;
        page_t stk;
        page_t mvr;
        page_t mvw;
    } page_file_t;

    typedef struct packed {
        page_t page;
        off_t  off;
    } phys_t;

    function automatic phys_t make_phys(page_t p, off_t o);
        phys_t r;
        r.page = p;
        r.off  = o;
        return r;
    endfunction

    // Plain, indexed and any unassigned code obey the page-mode enable.
    function automatic logic class_is_gated(logic [CLS_W-1:0] c);
        case (c)
            ACC_STACK, ACC_MVRD, ACC_MVWR: return 1'b0;
            default:                       return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pgmap_ptr_file.sv
module pgmap_ptr_file
    import pgmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SEL_W-1:0]   sel,
    input  page_t              wdata,
    output page_file_t         pages
);

    page_t ptr_q [NUM_PTR];

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[k] <= '0;
            else if (we && sel == SEL_W'(k))
                ptr_q[k] <= wdata;
        end

        // R7: a write to this slot appears after the edge
        p_ptr_load_r7: assert property (@(posedge clk) disable iff (rst)
            (we && sel == SEL_W'(k)) |=> (ptr_q[k] == $past(wdata)));

        // R7: slot holds when not addressed
        p_ptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !(we && sel == SEL_W'(k)) |=> $stable(ptr_q[k]));
    end

    always_comb begin
        pages.cur = ptr_q[PTR_CUR];
        pages.idx = ptr_q[PTR_IDX];
        pages.stk = ptr_q[PTR_STK];
        pages.mvr = ptr_q[PTR_MVR];
        pages.mvw = ptr_q[PTR_MVW];
    end

endmodule

// File: rtl/pgmap_mode_ctl.sv
module pgmap_mode_ctl (
    input  logic clk,
    input  logic rst,
    input  logic mode_we,
    input  logic mode_wdata,
    input  logic irq_enter,
    input  logic irq_return,
    output logic mode_on
);

    logic mode_q;
    logic saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            saved_q <= 1'b0;
        end else if (irq_enter) begin
            saved_q <= mode_q;
            mode_q  <= 1'b0;
        end else if (irq_return) begin
            mode_q  <= saved_q;
        end else if (mode_we) begin
            mode_q  <= mode_wdata;
        end
    end

    assign mode_on = mode_q;

    // R9: entry always lands in page-mode off
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
        irq_enter |=> !mode_q);

    // R9: return restores the value held before entry
    p_irq_restore_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_enter ##1 (irq_return && !irq_enter)) |=> (mode_q == $past(mode_q, 2)));

    // R8: plain write with no interrupt event
    p_mode_write_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_we && !irq_enter && !irq_return) |=> (mode_q == $past(mode_wdata)));

endmodule

// File: rtl/pgmap_page_sel.sv
module pgmap_page_sel
    import pgmap_pkg::*;
(
    input  logic [CLS_W-1:0] acc_class,
    input  logic             mode_on,
    input  page_file_t       pages,
    output page_t            page
);

    page_t raw;

    always_comb begin
        case (acc_class)
            ACC_INDEX: raw = pages.idx;
            ACC_STACK: raw = pages.stk;
            ACC_MVRD:  raw = pages.mvr;
            ACC_MVWR:  raw = pages.mvw;
            default:   raw = pages.cur;
        endcase
        if (class_is_gated(acc_class) && !mode_on)
            page = '0;
        else
            page = raw;
    end

endmodule

// File: rtl/paged_sram_mapper.sv
module paged_sram_mapper
    import pgmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OFF_W-1:0]   acc_addr,
    input  logic [CLS_W-1:0]   acc_class,
    input  logic               ptr_we,
    input  logic [SEL_W-1:0]   ptr_sel,
    input  logic [PG_W-1:0]    ptr_wdata,
    input  logic               mode_we,
    input  logic               mode_wdata,
    input  logic               irq_enter,
    input  logic               irq_return,
    output logic [PHYS_W-1:0]  phys_addr
);

    page_file_t pages;
    logic       mode_on;
    page_t      sel_page;
    phys_t      phys;

    pgmap_ptr_file u_ptrs (
        .clk   (clk),
        .rst   (rst),
        .we    (ptr_we),
        .sel   (ptr_sel),
        .wdata (ptr_wdata),
        .pages (pages)
    );

    pgmap_mode_ctl u_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .mode_on    (mode_on)
    );

    pgmap_page_sel u_sel (
        .acc_class (acc_class),
        .mode_on   (mode_on),
        .pages     (pages),
        .page      (sel_page)
    );

    always_comb phys = make_phys(sel_page, acc_addr);
    assign phys_addr = phys;

    // R2: offset passes straight through
    p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFF_W-1:0] == acc_addr);

    // R3 / R4 / R10: gated classes sit in page 0 while mode is off
    p_gated_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_on && acc_class != ACC_STACK && acc_class != ACC_MVRD
         && acc_class != ACC_MVWR) |-> (phys_addr[PHYS_W-1:OFF_W] == '0));

    // R5: stack traffic follows the stack pointer regardless of mode
    p_stack_page_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_class == ACC_STACK) |-> (phys_addr[PHYS_W-1:OFF_W] == pages.stk));

    // R6: move-indirect write follows its pointer regardless of mode
    p_mvwr_page_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_class == ACC_MVWR) |-> (phys_addr[PHYS_W-1:OFF_W] == pages.mvw));

endmodule

// File: tb/sim_paged_sram_mapper.sv
module sim_paged_sram_mapper;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  acc_addr;
    logic [2:0]  acc_class;
    logic        ptr_we;
    logic [2:0]  ptr_sel;
    logic [2:0]  ptr_wdata;
    logic        mode_we;
    logic        mode_wdata;
    logic        irq_enter;
    logic        irq_return;
    logic [10:0] phys_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    paged_sram_mapper u0 (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_class(acc_class),
        .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .irq_enter(irq_enter), .irq_return(irq_return),
        .phys_addr(phys_addr)
    );

    // Drive access at a falling edge, sample after settling.
    task automatic probe(input string tag, input logic [2:0] cls,
                         input logic [7:0] a, input logic [2:0] exp_pg);
        logic [10:0] exp;
        @(negedge clk);
        acc_class = cls;
        acc_addr  = a;
        #1;
        exp = {exp_pg, a};
        n_tests++;
        if (phys_addr !== exp) begin
            n_fail++;
            $display("FAIL %s class=%0d got=%h exp=%h", tag, cls, phys_addr, exp);
        end
    endtask

    task automatic wr_ptr(input logic [2:0] s, input logic [2:0] d);
        @(negedge clk);
        ptr_we = 1'b1; ptr_sel = s; ptr_wdata = d;
        @(negedge clk);
        ptr_we = 1'b0;
    endtask

    task automatic wr_mode(input logic v);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic pulse_irq(input logic enter, input logic ret, input logic mwe, input logic mv);
        @(negedge clk);
        irq_enter = enter; irq_return = ret; mode_we = mwe; mode_wdata = mv;
        @(negedge clk);
        irq_enter = 1'b0; irq_return = 1'b0; mode_we = 1'b0;
    endtask

    task automatic t_reset();
        for (int c = 0; c < 8; c++)
            probe("R1 reset state", 3'(c), 8'h5A, 3'd0);
    endtask

    task automatic t_load_all();
        wr_ptr(3'd0, 3'd5);
        wr_ptr(3'd1, 3'd3);
        wr_ptr(3'd2, 3'd6);
        wr_ptr(3'd3, 3'd2);
        wr_ptr(3'd4, 3'd7);
    endtask

    task automatic t_offset();
        probe("R2 offset low",  3'd2, 8'h00, 3'd6);
        probe("R2 offset high", 3'd2, 8'hFF, 3'd6);
        probe("R2 offset mid",  3'd4, 8'hA5, 3'd7);
    endtask

    task automatic t_gated_off();
        probe("R3 plain mode off",   3'd0, 8'h10, 3'd0);
        probe("R4 indexed mode off", 3'd1, 8'h20, 3'd0);
        probe("R5 stack mode off",   3'd2, 8'h30, 3'd6);
        probe("R6 mvrd mode off",    3'd3, 8'h40, 3'd2);
        probe("R6 mvwr mode off",    3'd4, 8'h50, 3'd7);
    endtask

    task automatic t_gated_on();
        wr_mode(1'b1);
        probe("R3 R8 plain mode on",  3'd0, 8'h11, 3'd5);
        probe("R4 indexed mode on",   3'd1, 8'h21, 3'd3);
        probe("R5 stack mode on",     3'd2, 8'h31, 3'd6);
        probe("R6 mvrd mode on",      3'd3, 8'h41, 3'd2);
        probe("R6 mvwr mode on",      3'd4, 8'h51, 3'd7);
    endtask

    task automatic t_undef_class();
        probe("R10 code5 mode on", 3'd5, 8'h66, 3'd5);
        probe("R10 code6 mode on", 3'd6, 8'h67, 3'd5);
        probe("R10 code7 mode on", 3'd7, 8'h68, 3'd5);
        wr_mode(1'b0);
        probe("R10 code7 mode off", 3'd7, 8'h69, 3'd0);
        wr_mode(1'b1);
    endtask

    task automatic t_bad_sel();
        for (int s = 5; s < 8; s++) wr_ptr(3'(s), 3'd1);
        probe("R7 bad sel cur", 3'd0, 8'h01, 3'd5);
        probe("R7 bad sel idx", 3'd1, 8'h02, 3'd3);
        probe("R7 bad sel stk", 3'd2, 8'h03, 3'd6);
        probe("R7 bad sel mvr", 3'd3, 8'h04, 3'd2);
        probe("R7 bad sel mvw", 3'd4, 8'h05, 3'd7);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        ptr_we = 1'b1; ptr_sel = 3'd0; ptr_wdata = 3'd4;
        acc_class = 3'd0; acc_addr = 8'h77;
        #1;
        n_tests++;
        if (phys_addr !== {3'd5, 8'h77}) begin
            n_fail++;
            $display("FAIL R7 pre-edge got=%h exp=%h", phys_addr, {3'd5, 8'h77});
        end
        @(negedge clk);
        ptr_we = 1'b0;
        #1;
        n_tests++;
        if (phys_addr !== {3'd4, 8'h77}) begin
            n_fail++;
            $display("FAIL R7 post-edge got=%h exp=%h", phys_addr, {3'd4, 8'h77});
        end
        wr_ptr(3'd0, 3'd5);
    endtask

    task automatic t_irq();
        // mode currently 1
        pulse_irq(1'b1, 1'b0, 1'b1, 1'b1);   // entry beats mode write
        probe("R9 entry clears plain",  3'd0, 8'h80, 3'd0);
        probe("R9 entry stack kept",    3'd2, 8'h81, 3'd6);
        pulse_irq(1'b0, 1'b1, 1'b0, 1'b0);
        probe("R9 return restores on",  3'd0, 8'h82, 3'd5);
        wr_mode(1'b0);
        pulse_irq(1'b1, 1'b0, 1'b0, 1'b0);
        pulse_irq(1'b0, 1'b1, 1'b0, 1'b0);
        probe("R9 return restores off", 3'd1, 8'h83, 3'd0);
        wr_mode(1'b1);
        probe("R8 mode rewritten", 3'd1, 8'h84, 3'd3);
    endtask

    initial begin
        rst = 1'b1; acc_addr = '0; acc_class = '0;
        ptr_we = 1'b0; ptr_sel = '0; ptr_wdata = '0;
        mode_we = 1'b0; mode_wdata = 1'b0;
        irq_enter = 1'b0; irq_return = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_all();
        t_offset();
        t_gated_off();
        t_gated_on();
        t_undef_class();
        t_bad_sel();
        t_write_timing();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule